// File: doc/BRIEF.md
# Receive Buffer Descriptor Queue

This block keeps track of the empty memory buffers that software hands over for incoming packets, and of the buffers that have already been filled. Software first writes a buffer capacity into the size register. It then writes the buffer address into the queue register, which queues one free-buffer descriptor holding the address and the capacity. When the packet source signals that a packet is ready and a free buffer is queued, the block accepts the packet and hands the oldest free buffer to the receive DMA side. When the DMA side reports completion, the block records the delivered length and a status code for that buffer.

Software collects results in two steps. A read of the size register shows the length of the oldest completed packet without removing it. A read of the queue register then removes that entry and returns its status. Free buffers and completed entries share one depth budget, and software can read that depth from its own register.

A three-state machine sequences each transfer. In Idle it waits for a packet and a free buffer. The transition accept (Idle to Transfer) pops the free buffer and captures the packet length. Transfer holds the DMA request until the DMA side reports done. The transition done (Transfer to Commit) captures the error flag. Commit writes the completed entry in one cycle and then takes the transition retire (Commit to Idle).

Top module: `rxbuf_desc_queue`

## Requirements
- R1: A write to the queue register (address 1) pushes a descriptor made of the write data as the address and the last value written to the size register (address 0, low LEN_W bits) as the capacity. Buffers are handed to the DMA side in push order, with `dma_addr` and `dma_cap` equal to the queued values.
- R2: A read of the size register (address 0) returns the recorded length of the oldest completed entry, zero-extended. The read does not remove the entry, and it returns 0 when no completed entry waits.
- R3: A read of the queue register (address 1) removes the oldest completed entry and returns its status. It returns 0 and removes nothing when no completed entry waits.
- R4: The status is 1 when the packet fits the buffer and no DMA error is reported. It is 2 when the packet length exceeds the capacity, and the recorded length and `dma_len` are then clamped to the capacity. It is 3 when `dma_err` is high with `dma_done`, and status 3 takes precedence over status 2.
- R5: `pkt_ready` is high only in Idle, while `pkt_avail` is high and at least one free buffer is queued. It stays low when no free buffer is queued. The cycle after `pkt_ready` is high, `dma_req` is high.
- R6: Free entries, the entry in flight and completed entries together never exceed DEPTH. A push that would exceed DEPTH is ignored. A read of address 2 returns DEPTH, and a read of address 3 returns 0.
- R7: `dma_req` stays high in Transfer until `dma_done`. The cycle after done it is low (Commit), and the completed entry is readable one cycle later.
- R8: `rx_pending` is high exactly while at least one completed entry waits to be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (reads of address 1 pop) |
| reg_addr | input | 2 | 0 size, 1 queue, 2 depth, 3 unused |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid in the cycle `reg_rd` is high |
| rx_pending | output | 1 | A completed entry waits |
| pkt_avail | input | 1 | Packet source has a packet |
| pkt_len | input | LEN_W | Length of the offered packet |
| pkt_ready | output | 1 | Packet accepted at this clock edge |
| dma_req | output | 1 | Transfer request to DMA side |
| dma_addr | output | ADDR_W | Buffer address for the transfer |
| dma_cap | output | LEN_W | Buffer capacity |
| dma_len | output | LEN_W | Bytes to write (length clamped to capacity) |
| dma_done | input | 1 | DMA side finished the transfer |
| dma_err | input | 1 | DMA side reports an error, qualified by `dma_done` |

## Verification
The checker watches the handshake on every cycle. It checks that `pkt_ready` only appears with `pkt_avail` and outside a transfer, and that a request follows each accept. It also checks that the request holds until done and drops in Commit, that the clamped length never exceeds the capacity, that the shared occupancy stays within DEPTH, and that reads return 0 or a legal status depending on `rx_pending`. Only the bench scenarios can show the ordering of buffers and results, the size-then-address pairing, the clamping and error codes for particular lengths, and that pushes made while the budget is full leave no trace in later transfers.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // transfer sequencing states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_XFER   = 2'd1,
        ST_COMMIT = 2'd2
    } xfer_state_t;

    // completion status codes
    localparam int STAT_W         = 8;
    localparam logic [STAT_W-1:0] RX_STAT_OK   = 8'd1;
    localparam logic [STAT_W-1:0] RX_STAT_OVER = 8'd2;
    localparam logic [STAT_W-1:0] RX_STAT_BERR = 8'd3;

    // register map
    localparam logic [1:0] REG_SIZE  = 2'd0;
    localparam logic [1:0] REG_QUEUE = 2'd1;
    localparam logic [1:0] REG_DEPTH = 2'd2;

endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign do_push = push && (count != CNT_W'(DEPTH));
    assign do_pop  = pop && (count != '0);

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem[gi] <= '0;
                end else if (do_push && (wr_ptr == PTR_W'(gi))) begin
                    mem[gi] <= din;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout = mem[rd_ptr];

endmodule

// File: rtl/rxq_xfer_fsm.sv
module rxq_xfer_fsm
    import rxq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_avail,
    input  logic [LEN_W-1:0]  pkt_len,
    output logic              pkt_ready,
    input  logic              free_valid,
    input  logic [ADDR_W-1:0] free_addr,
    input  logic [LEN_W-1:0]  free_cap,
    output logic              free_pop,
    output logic              dma_req,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [LEN_W-1:0]  dma_cap,
    output logic [LEN_W-1:0]  dma_len,
    input  logic              dma_done,
    input  logic              dma_err,
    output logic              done_push,
    output logic [LEN_W-1:0]  done_len,
    output logic [STAT_W-1:0] done_stat
);

    xfer_state_t state_q, state_d;

    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  cur_cap;
    logic [LEN_W-1:0]  cur_len;
    logic              cur_over;
    logic              cur_err;
    logic              accept;
    logic              over_now;

    assign accept   = (state_q == ST_IDLE) && pkt_avail && free_valid;
    assign over_now = pkt_len > free_cap;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)   state_d = ST_XFER;
            ST_XFER:   if (dma_done) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // per-transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_cap  <= '0;
            cur_len  <= '0;
            cur_over <= 1'b0;
            cur_err  <= 1'b0;
        end else begin
            if (accept) begin
                cur_addr <= free_addr;
                cur_cap  <= free_cap;
                cur_len  <= over_now ? free_cap : pkt_len;
                cur_over <= over_now;
                cur_err  <= 1'b0;
            end else if ((state_q == ST_XFER) && dma_done) begin
                cur_err <= dma_err;
            end
        end
    end

    // outputs
    always_comb begin
        pkt_ready = 1'b0;
        free_pop  = 1'b0;
        dma_req   = 1'b0;
        done_push = 1'b0;
        done_stat = RX_STAT_OK;
        unique case (state_q)
            ST_IDLE: begin
                pkt_ready = accept;
                free_pop  = accept;
            end
            ST_XFER: begin
                dma_req = 1'b1;
            end
            ST_COMMIT: begin
                done_push = 1'b1;
                if (cur_err) begin
                    done_stat = RX_STAT_BERR;
                end else if (cur_over) begin
                    done_stat = RX_STAT_OVER;
                end else begin
                    done_stat = RX_STAT_OK;
                end
            end
            default: begin
                done_push = 1'b0;
            end
        endcase
    end

    assign dma_addr = cur_addr;
    assign dma_cap  = cur_cap;
    assign dma_len  = cur_len;
    assign done_len = cur_len;

endmodule

// File: rtl/rxq_regif.sv
module rxq_regif
    import rxq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              free_push,
    output logic [ADDR_W-1:0] free_addr_in,
    output logic [LEN_W-1:0]  free_cap_in,
    input  logic              done_valid,
    input  logic [LEN_W-1:0]  done_len_head,
    input  logic [STAT_W-1:0] done_stat_head,
    output logic              done_pop,
    output logic [CNT_W-1:0]  total_cnt
);

    logic [LEN_W-1:0] pend_cap;
    logic             push_req;

    assign push_req     = reg_wr && (reg_addr == REG_QUEUE);
    assign free_push    = push_req && (total_cnt != CNT_W'(DEPTH));
    assign free_addr_in = reg_wdata[ADDR_W-1:0];
    assign free_cap_in  = pend_cap;
    assign done_pop     = reg_rd && (reg_addr == REG_QUEUE) && done_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_cap <= '0;
        end else if (reg_wr && (reg_addr == REG_SIZE)) begin
            pend_cap <= reg_wdata[LEN_W-1:0];
        end
    end

    // shared budget: free + in flight + completed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_cnt <= '0;
        end else begin
            unique case ({free_push, done_pop})
                2'b10:   total_cnt <= total_cnt + 1'b1;
                2'b01:   total_cnt <= total_cnt - 1'b1;
                default: total_cnt <= total_cnt;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_addr)
                REG_SIZE:  reg_rdata = done_valid ? DATA_W'(done_len_head) : '0;
                REG_QUEUE: reg_rdata = done_valid ? DATA_W'(done_stat_head) : '0;
                REG_DEPTH: reg_rdata = DATA_W'(DEPTH);
                default:   reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/rxbuf_desc_queue.sv
module rxbuf_desc_queue
    import rxq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              rx_pending,
    input  logic              pkt_avail,
    input  logic [LEN_W-1:0]  pkt_len,
    output logic              pkt_ready,
    output logic              dma_req,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [LEN_W-1:0]  dma_cap,
    output logic [LEN_W-1:0]  dma_len,
    input  logic              dma_done,
    input  logic              dma_err
);

    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int FREE_W = ADDR_W + LEN_W;
    localparam int DONE_W = LEN_W + STAT_W;

    logic              free_push;
    logic [ADDR_W-1:0] free_addr_in;
    logic [LEN_W-1:0]  free_cap_in;
    logic              free_pop;
    logic [FREE_W-1:0] free_head;
    logic [CNT_W-1:0]  free_cnt;

    logic              done_push;
    logic [LEN_W-1:0]  done_len;
    logic [STAT_W-1:0] done_stat;
    logic              done_pop;
    logic [DONE_W-1:0] done_head;
    logic [CNT_W-1:0]  done_cnt;
    logic [CNT_W-1:0]  total_cnt;

    rxq_fifo #(.W(FREE_W), .DEPTH(DEPTH)) u_free_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (free_push),
        .din   ({free_addr_in, free_cap_in}),
        .pop   (free_pop),
        .dout  (free_head),
        .count (free_cnt)
    );

    rxq_fifo #(.W(DONE_W), .DEPTH(DEPTH)) u_done_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (done_push),
        .din   ({done_len, done_stat}),
        .pop   (done_pop),
        .dout  (done_head),
        .count (done_cnt)
    );

    rxq_xfer_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_avail  (pkt_avail),
        .pkt_len    (pkt_len),
        .pkt_ready  (pkt_ready),
        .free_valid (free_cnt != '0),
        .free_addr  (free_head[FREE_W-1:LEN_W]),
        .free_cap   (free_head[LEN_W-1:0]),
        .free_pop   (free_pop),
        .dma_req    (dma_req),
        .dma_addr   (dma_addr),
        .dma_cap    (dma_cap),
        .dma_len    (dma_len),
        .dma_done   (dma_done),
        .dma_err    (dma_err),
        .done_push  (done_push),
        .done_len   (done_len),
        .done_stat  (done_stat)
    );

    rxq_regif #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .DEPTH  (DEPTH)
    ) u_regif (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr         (reg_wr),
        .reg_rd         (reg_rd),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .free_push      (free_push),
        .free_addr_in   (free_addr_in),
        .free_cap_in    (free_cap_in),
        .done_valid     (done_cnt != '0),
        .done_len_head  (done_head[DONE_W-1:STAT_W]),
        .done_stat_head (done_head[STAT_W-1:0]),
        .done_pop       (done_pop),
        .total_cnt      (total_cnt)
    );

    assign rx_pending = (done_cnt != '0);

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              rx_pending,
    input logic              pkt_avail,
    input logic              pkt_ready,
    input logic              dma_req,
    input logic              dma_done,
    input logic [LEN_W-1:0]  dma_len,
    input logic [LEN_W-1:0]  dma_cap,
    input logic [CNT_W-1:0]  total_cnt
);

    // R5
    ready_needs_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |-> (pkt_avail && !dma_req));

    // R5
    accept_starts_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |=> dma_req);

    // R7
    req_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_done) |=> dma_req);

    // R7
    req_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_done) |=> (!dma_req && !pkt_ready));

    // R4
    len_clamped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (dma_len <= dma_cap));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        total_cnt <= CNT_W'(DEPTH));

    // R3
    status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd1 && rx_pending) |->
            (reg_rdata >= 1 && reg_rdata <= 3));

    // R2
    empty_size_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr != 2'd2 && !rx_pending) |-> (reg_rdata == '0));

endmodule

bind rxbuf_desc_queue rxq_chk #(
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) u_rxq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .rx_pending (rx_pending),
    .pkt_avail  (pkt_avail),
    .pkt_ready  (pkt_ready),
    .dma_req    (dma_req),
    .dma_done   (dma_done),
    .dma_len    (dma_len),
    .dma_cap    (dma_cap),
    .total_cnt  (total_cnt)
);

// File: tb/test_rxbuf_desc_queue.sv
`timescale 1ns/1ps
module test_rxbuf_desc_queue;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam int DEPTH  = 4;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  cap;
    } buf_t;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  cap;
        logic [LEN_W-1:0]  len;
    } xfer_t;

    typedef struct {
        logic [LEN_W-1:0] len;
        logic [7:0]       stat;
    } done_t;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              reg_wr, reg_rd;
    logic [1:0]        reg_addr;
    logic [DATA_W-1:0] reg_wdata;
    logic [DATA_W-1:0] reg_rdata;
    logic              rx_pending;
    logic              pkt_avail;
    logic [LEN_W-1:0]  pkt_len;
    logic              pkt_ready;
    logic              dma_req;
    logic [ADDR_W-1:0] dma_addr;
    logic [LEN_W-1:0]  dma_cap;
    logic [LEN_W-1:0]  dma_len;
    logic              dma_done, dma_err;

    int    errors = 0;
    int    checks = 0;
    buf_t  exp_buf[$];
    xfer_t exp_xfer[$];
    done_t exp_done[$];
    logic  seen_req = 1'b0;
    logic  finished = 1'b0;

    always #2 clk = ~clk;

    rxbuf_desc_queue #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(DEPTH)
    ) i_rxbuf_desc_queue (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_pending(rx_pending),
        .pkt_avail(pkt_avail), .pkt_len(pkt_len), .pkt_ready(pkt_ready),
        .dma_req(dma_req), .dma_addr(dma_addr), .dma_cap(dma_cap),
        .dma_len(dma_len), .dma_done(dma_done), .dma_err(dma_err)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: compares each new DMA request with the scoreboard
    always @(negedge clk) begin
        if (rst_n && dma_req && !seen_req) begin
            seen_req <= 1'b1;
            if (exp_xfer.size() == 0) begin
                check("R5", "unexpected request", 32'd1, 32'd0);
            end else begin
                xfer_t x;
                x = exp_xfer.pop_front();
                check("R1", "dma_addr", dma_addr, x.addr);
                check("R1", "dma_cap", 32'(dma_cap), 32'(x.cap));
                check("R4", "dma_len", 32'(dma_len), 32'(x.len));
            end
        end else if (!dma_req) begin
            seen_req <= 1'b0;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // driver: push one buffer and record it
    task automatic push_buf(input logic [31:0] addr, input logic [15:0] cap);
        buf_t b;
        wr(2'd0, 32'(cap));
        wr(2'd1, addr);
        b.addr = addr; b.cap = cap;
        exp_buf.push_back(b);
    endtask

    task automatic send_pkt(input logic [15:0] len, input logic err);
        buf_t  b;
        xfer_t x;
        done_t d;
        pkt_avail = 1'b1; pkt_len = len;
        #1;
        while (!pkt_ready) begin
            @(negedge clk);
            #1;
        end
        b = exp_buf.pop_front();
        x.addr = b.addr; x.cap = b.cap;
        x.len  = (len > b.cap) ? b.cap : len;
        exp_xfer.push_back(x);
        d.len  = x.len;
        d.stat = err ? 8'd3 : ((len > b.cap) ? 8'd2 : 8'd1);
        exp_done.push_back(d);
        @(negedge clk);
        pkt_avail = 1'b0;
        check("R5", "dma_req after accept", 32'(dma_req), 32'd1);
        repeat (3) @(negedge clk);
        check("R7", "dma_req held", 32'(dma_req), 32'd1);
        dma_done = 1'b1; dma_err = err;
        @(negedge clk);
        dma_done = 1'b0; dma_err = 1'b0;
        check("R7", "dma_req low in commit", 32'(dma_req), 32'd0);
        @(negedge clk);
    endtask

    task automatic drain_one();
        done_t d;
        logic [31:0] v;
        d = exp_done.pop_front();
        check("R8", "rx_pending before pop", 32'(rx_pending), 32'd1);
        rd(2'd0, v);
        check("R2", "size read", v, 32'(d.len));
        rd(2'd0, v);
        check("R2", "size read again (no pop)", v, 32'(d.len));
        rd(2'd1, v);
        check("R3", "status pop", v, 32'(d.stat));
    endtask

    task automatic no_ready(input int n, input string req);
        pkt_avail = 1'b1; pkt_len = 16'd8;
        for (int i = 0; i < n; i++) begin
            #1 check(req, "pkt_ready without buffer", 32'(pkt_ready), 32'd0);
            @(negedge clk);
        end
        pkt_avail = 1'b0;
        check(req, "no request", 32'(dma_req), 32'd0);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        pkt_avail = 1'b0; pkt_len = '0; dma_done = 1'b0; dma_err = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(2'd0, v); check("R2", "size empty", v, 32'd0);
        rd(2'd1, v); check("R3", "queue empty", v, 32'd0);
        rd(2'd2, v); check("R6", "depth reg", v, 32'(DEPTH));
        rd(2'd3, v); check("R6", "unused reg", v, 32'd0);
        check("R8", "rx_pending reset", 32'(rx_pending), 32'd0);
        no_ready(5, "R5");

        // basic receive
        push_buf(32'h0000_1000, 16'd100);
        send_pkt(16'd60, 1'b0);
        drain_one();
        rd(2'd1, v); check("R3", "second pop empty", v, 32'd0);
        check("R8", "rx_pending after drain", 32'(rx_pending), 32'd0);

        // oversize, bus error, exact fit; results in order
        push_buf(32'h0000_2000, 16'd50);
        push_buf(32'h0000_3000, 16'd64);
        push_buf(32'h0000_4000, 16'd32);
        send_pkt(16'd80, 1'b0);
        send_pkt(16'd70, 1'b1);
        send_pkt(16'd32, 1'b0);
        drain_one();
        drain_one();
        drain_one();

        // shared budget
        for (int i = 0; i < DEPTH; i++) begin
            push_buf(32'h0001_0000 + 32'(i), 16'd40 + 16'(i));
        end
        wr(2'd0, 32'd99); wr(2'd1, 32'h0000_5555);   // ignored, R6
        for (int i = 0; i < DEPTH; i++) begin
            send_pkt(16'd20 + 16'(i), 1'b0);
        end
        no_ready(4, "R6");
        wr(2'd0, 32'd99); wr(2'd1, 32'h0000_6666);   // ignored, R6 (completed entries count)
        for (int i = 0; i < DEPTH; i++) drain_one();

        push_buf(32'h0000_7777, 16'd20);
        send_pkt(16'd10, 1'b0);                       // R1: 7777 follows, no stale buffer
        drain_one();
        no_ready(3, "R6");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule